// File: doc/BRIEF.md
# SPI Flash Command Engine

This block turns a handful of byte-wide register writes into one complete SPI flash transaction. A host first lifts a write lock, then pushes an opcode followed by any payload bytes into a single queue port. It programs one byte that packs the payload count and the read count, and finally writes a control byte with the start bit set. The engine then holds chip select low, shifts out the opcode, the payload and, unless the read phase is skipped, clocks in the requested number of reply bytes.

Received bytes land in a small buffer that the host empties one byte per read of the receive port. The start bit doubles as the busy flag: it reads as one until chip select has been released, so the host simply polls it. The host port is a plain synchronous byte register interface; whatever serial transport feeds it lives outside this block.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset chip select is high, SCLK is low, the lock is engaged (register 0xB3 reads 0x00) and the control register at 0x93 reads 0x00.
- R2: Writing 0x10 to 0xB3 unlocks and makes it read 0x10; writing 0x00 locks again. While locked, writes to 0x90, 0x92 and 0x93 have no effect.
- R3: The first byte written to 0x90 after the queue is emptied is the opcode; each later write appends one payload byte, up to 16 entries in total.
- R4: Register 0x92 reads back as written; bits 3:0 give the payload byte count W sent after the opcode, bits 7:4 give the reply byte count minus one (R).
- R5: Writing 0x93 with bit 0 set starts a transaction of 1+W+(R+1) bytes, or 1+W bytes when bit 2 (skip reply) is also set.
- R6: Bit 0 of 0x93 reads 1 from the cycle after the start write until chip select is released, then reads 0.
- R7: SPI mode 0, MSB first: SCLK idles low, MOSI changes only after a falling edge, MISO is sampled on the rising edge, and each SCLK half period lasts SCK_HALF clock cycles.
- R8: Chip select stays low over the whole opcode, payload and reply sequence and rises exactly 2*SCK_HALF clock cycles after the last falling SCLK edge.
- R9: Payload positions beyond the number of queued bytes are sent as 0x00, as is every byte of the reply phase.
- R10: Reads of 0x91 return the reply bytes in arrival order; once all are consumed further reads return 0x00 and do not advance.
- R11: Writing 0x93 with bit 1 set empties the queue and the reply buffer; the queue also empties itself when a transaction ends and the reply buffer when one starts.
- R12: A write to 0x93 while busy is ignored; bits 2, 3 and 4 of an accepted write are held and read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops the receive port) |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid in the same cycle as the address |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The main function is swept over every payload count from 0 to 15, each combined with a one-byte reply, a mid-size reply, the full 16-byte reply and the skipped reply, so that errors in the nibble decode, the byte total and the phase boundary each show up as a wrong byte count or a misplaced byte. Every third payload count queues only half the bytes it asks for, which separates zero filling from stale queue contents. The reply model returns a distinct value for each byte position, so shifted, reordered or dropped reply bytes are told apart, and one extra read after each drain separates an empty buffer from a wrapped pointer. Separate cases cover locked writes, the pointer clear bit and control writes issued while busy.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_WAIT,
      SQ_TAIL
   } seq_state_e;

   typedef struct packed {
      logic mode;
      logic readback;
      logic skip_rd;
   } ctrl_hold_t;

   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_CLR_BIT  = 1;
   localparam int CTRL_SKIP_BIT = 2;
   localparam int CTRL_RB_BIT   = 3;
   localparam int CTRL_MODE_BIT = 4;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] QUEUE_ADDR = 8'h90,
   parameter logic [ADDR_W-1:0] RXP_ADDR   = 8'h91,
   parameter logic [ADDR_W-1:0] SIZE_ADDR  = 8'h92,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h93,
   parameter logic [ADDR_W-1:0] LOCK_ADDR  = 8'hB3,
   parameter logic [DATA_W-1:0] OPEN_CODE  = 8'h10,
   parameter logic [DATA_W-1:0] SHUT_CODE  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              busy,
   input  logic              seq_done,
   input  logic              rx_we,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [LEN_W-1:0]  tx_idx,
   output logic [DATA_W-1:0] tx_byte,
   output logic [LEN_W-1:0]  wr_len,
   output logic [LEN_W-1:0]  rd_len_m1,
   output logic              skip_rd,
   output logic              go,
   output logic              unlocked,
   output logic [LEN_W:0]    rx_rptr,
   output logic [LEN_W:0]    rx_wptr
);
   localparam int DEPTH = 1 << LEN_W;
   localparam int PW    = LEN_W + 1;
   localparam logic [PW-1:0] FULL = PW'(DEPTH);

   logic [DATA_W-1:0] q_mem  [DEPTH];
   logic [DATA_W-1:0] rx_mem [DEPTH];
   logic [PW-1:0]     q_ptr;
   logic [LEN_W-1:0]  wlen_q, rlen_q;
   ctrl_hold_t        hold_q;
   logic              open_q;

   logic sel_q, sel_rx, sel_sz, sel_ct, sel_lk, wr_ok, clr, q_push, rx_pop;

   assign sel_q  = (host_addr == QUEUE_ADDR);
   assign sel_rx = (host_addr == RXP_ADDR);
   assign sel_sz = (host_addr == SIZE_ADDR);
   assign sel_ct = (host_addr == CTRL_ADDR);
   assign sel_lk = (host_addr == LOCK_ADDR);
   assign wr_ok  = host_wr & open_q & ~busy;
   assign go     = wr_ok & sel_ct & host_wdata[CTRL_GO_BIT];
   assign clr    = wr_ok & sel_ct & host_wdata[CTRL_CLR_BIT];
   assign q_push = wr_ok & sel_q & (q_ptr < FULL);
   assign rx_pop = host_rd & sel_rx & (rx_rptr < rx_wptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         wlen_q  <= '0;
         rlen_q  <= '0;
         hold_q  <= '0;
         q_ptr   <= '0;
         rx_wptr <= '0;
         rx_rptr <= '0;
      end else begin
         if (host_wr && sel_lk) begin
            if (host_wdata == OPEN_CODE)      open_q <= 1'b1;
            else if (host_wdata == SHUT_CODE) open_q <= 1'b0;
         end
         if (wr_ok && sel_sz) begin
            wlen_q <= host_wdata[LEN_W-1:0];
            rlen_q <= host_wdata[2*LEN_W-1:LEN_W];
         end
         if (wr_ok && sel_ct) begin
            hold_q.mode     <= host_wdata[CTRL_MODE_BIT];
            hold_q.readback <= host_wdata[CTRL_RB_BIT];
            hold_q.skip_rd  <= host_wdata[CTRL_SKIP_BIT];
         end
         if (clr || seq_done)  q_ptr <= '0;
         else if (q_push)      q_ptr <= q_ptr + 1'b1;
         if (clr || go)        rx_wptr <= '0;
         else if (rx_we && rx_wptr < FULL) rx_wptr <= rx_wptr + 1'b1;
         if (clr || go)        rx_rptr <= '0;
         else if (rx_pop)      rx_rptr <= rx_rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (q_push) q_mem[q_ptr[LEN_W-1:0]] <= host_wdata;
      if (rx_we && rx_wptr < FULL) rx_mem[rx_wptr[LEN_W-1:0]] <= rx_byte;
   end

   assign tx_byte   = ({1'b0, tx_idx} < q_ptr) ? q_mem[tx_idx] : '0;
   assign wr_len    = wlen_q;
   assign rd_len_m1 = rlen_q;
   assign skip_rd   = hold_q.skip_rd;
   assign unlocked  = open_q;

   always_comb begin
      host_rdata = '0;
      if (sel_sz) begin
         host_rdata[2*LEN_W-1:0] = {rlen_q, wlen_q};
      end else if (sel_ct) begin
         host_rdata[CTRL_GO_BIT]   = busy;
         host_rdata[CTRL_SKIP_BIT] = hold_q.skip_rd;
         host_rdata[CTRL_RB_BIT]   = hold_q.readback;
         host_rdata[CTRL_MODE_BIT] = hold_q.mode;
      end else if (sel_rx) begin
         if (rx_rptr < rx_wptr) host_rdata = rx_mem[rx_rptr[LEN_W-1:0]];
      end else if (sel_lk) begin
         host_rdata = open_q ? OPEN_CODE : SHUT_CODE;
      end
   end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
   parameter int DATA_W   = 8,
   parameter int SCK_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [DATA_W-1:0] rx
);
   localparam int HW = $clog2(2 * DATA_W);
   localparam logic [HW-1:0] LAST_HALF = HW'(2 * DATA_W - 1);

   logic              active, tick;
   logic [HW-1:0]     half;
   logic [DATA_W-1:0] sh;

   generate
      if (SCK_HALF == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int DW = $clog2(SCK_HALF);
         localparam logic [DW-1:0] DIV_END = DW'(SCK_HALF - 1);
         logic [DW-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  div <= '0;
            else if (start || !active)   div <= '0;
            else if (div == DIV_END)     div <= '0;
            else                         div <= div + 1'b1;
         end
         assign tick = active && (div == DIV_END);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk   <= 1'b0;
         half   <= '0;
         sh     <= '0;
         rx     <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            sh     <= tx;
            half   <= '0;
            sclk   <= 1'b0;
         end else if (tick) begin
            sclk <= ~sclk;
            half <= half + 1'b1;
            if (!sclk) begin
               rx <= {rx[DATA_W-2:0], miso};
            end else if (half == LAST_HALF) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               sh <= {sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign mosi = active & sh[DATA_W-1];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_cmd_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 4,
   parameter int SCK_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [LEN_W-1:0]  rd_len_m1,
   input  logic              skip_rd,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [LEN_W-1:0]  tx_idx,
   input  logic              shift_done,
   output logic              shift_start,
   output logic [DATA_W-1:0] shift_tx,
   output logic              rx_we,
   output logic              busy,
   output logic              seq_done,
   output logic              cs_n
);
   localparam int IW = LEN_W + 2;
   localparam int TW = $clog2(2 * SCK_HALF) + 1;
   localparam logic [TW-1:0] TAIL_END = TW'(2 * SCK_HALF - 2);

   seq_state_e    state;
   logic [IW-1:0] idx, last_idx;
   logic [TW-1:0] tail_cnt;
   logic          write_phase;

   assign last_idx    = IW'(wr_len) + (skip_rd ? '0 : IW'(rd_len_m1) + 1'b1);
   assign write_phase = (idx <= IW'(wr_len));
   assign tx_idx      = idx[LEN_W-1:0];
   assign shift_tx    = write_phase ? tx_byte : '0;
   assign shift_start = (state == SQ_LOAD);
   assign rx_we       = (state == SQ_WAIT) && shift_done && !write_phase;
   assign seq_done    = (state == SQ_TAIL) && (tail_cnt == TAIL_END);
   assign busy        = (state != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         idx      <= '0;
         tail_cnt <= '0;
         cs_n     <= 1'b1;
      end else begin
         unique case (state)
            SQ_IDLE: if (go) begin
               state <= SQ_LOAD;
               idx   <= '0;
               cs_n  <= 1'b0;
            end
            SQ_LOAD: state <= SQ_WAIT;
            SQ_WAIT: if (shift_done) begin
               if (idx == last_idx) begin
                  state    <= SQ_TAIL;
                  tail_cnt <= '0;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= SQ_LOAD;
               end
            end
            SQ_TAIL: if (tail_cnt == TAIL_END) begin
               state <= SQ_IDLE;
               cs_n  <= 1'b1;
            end else begin
               tail_cnt <= tail_cnt + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 4,
   parameter int ADDR_W   = 8,
   parameter int SCK_HALF = 2,
   parameter logic [ADDR_W-1:0] QUEUE_ADDR = 8'h90,
   parameter logic [ADDR_W-1:0] RXP_ADDR   = 8'h91,
   parameter logic [ADDR_W-1:0] SIZE_ADDR  = 8'h92,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h93,
   parameter logic [ADDR_W-1:0] LOCK_ADDR  = 8'hB3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   generate
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
      if (LEN_W < 2 || 2 * LEN_W > DATA_W) begin : g_bad_len
         $error("two LEN_W nibbles must fit in one DATA_W byte");
      end
      if (DATA_W < 5) begin : g_bad_data
         $error("DATA_W must hold the five control bits");
      end
   endgenerate

   logic              busy, seq_done, rx_we, go, unlocked, skip_rd;
   logic              shift_start, shift_done;
   logic [DATA_W-1:0] tx_byte, shift_tx, rx_byte;
   logic [LEN_W-1:0]  tx_idx, wr_len, rd_len_m1;
   logic [LEN_W:0]    rx_rptr, rx_wptr;

   spi_cmd_regs #(
      .DATA_W(DATA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
      .QUEUE_ADDR(QUEUE_ADDR), .RXP_ADDR(RXP_ADDR), .SIZE_ADDR(SIZE_ADDR),
      .CTRL_ADDR(CTRL_ADDR), .LOCK_ADDR(LOCK_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .seq_done(seq_done), .rx_we(rx_we), .rx_byte(rx_byte),
      .tx_idx(tx_idx), .tx_byte(tx_byte), .wr_len(wr_len),
      .rd_len_m1(rd_len_m1), .skip_rd(skip_rd), .go(go),
      .unlocked(unlocked), .rx_rptr(rx_rptr), .rx_wptr(rx_wptr)
   );

   spi_cmd_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SCK_HALF(SCK_HALF)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .wr_len(wr_len),
      .rd_len_m1(rd_len_m1), .skip_rd(skip_rd), .tx_byte(tx_byte),
      .tx_idx(tx_idx), .shift_done(shift_done), .shift_start(shift_start),
      .shift_tx(shift_tx), .rx_we(rx_we), .busy(busy),
      .seq_done(seq_done), .cs_n(spi_cs_n)
   );

   spi_cmd_shifter #(.DATA_W(DATA_W), .SCK_HALF(SCK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(shift_start), .tx(shift_tx),
      .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
      .done(shift_done), .rx(rx_byte)
   );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PW     = 5,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h93
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              spi_cs_n,
   input logic              spi_sclk,
   input logic              spi_mosi,
   input logic              busy,
   input logic              unlocked,
   input logic              go,
   input logic [PW-1:0]     rx_rptr,
   input logic [PW-1:0]     rx_wptr
);
   assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   assert_locked_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !busy && host_wr && host_addr == CTRL_ADDR && host_wdata[0])
      |=> (spi_cs_n && !busy));

   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (busy && !spi_cs_n));

   assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);

   assert_rx_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rptr <= rx_wptr);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW(LEN_W + 1), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
   .host_wdata(host_wdata), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
   .spi_mosi(spi_mosi), .busy(busy), .unlocked(unlocked), .go(go),
   .rx_rptr(rx_rptr), .rx_wptr(rx_wptr)
);

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/100ps
module spi_cmd_engine_test;
   localparam int H = 2;
   localparam logic [7:0] A_Q = 8'h90, A_RX = 8'h91, A_SZ = 8'h92,
                          A_CT = 8'h93, A_LK = 8'hB3;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
   logic       spi_sclk, spi_mosi, spi_cs_n;
   logic       spi_miso = 1'b0;

   int checks = 0, errors = 0, cyc = 0;

   spi_cmd_engine #(.SCK_HALF(H)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   always #2.5 clk = ~clk;

   function automatic logic [7:0] resp(int k);
      return 8'((k * 29 + 90) & 255);
   endfunction
   function automatic logic [7:0] pay(int w, int i);
      return 8'(((i * 7 + w) & 255) ^ 8'h80);
   endfunction

   // flash model
   logic [7:0] mbytes [64];
   logic [7:0] msh = '0;
   int   bitcnt = 0, cs_falls = 0, hi_bad = 0;
   realtime t_rise = 0, t_fall = 0, gap = 0;

   always @(negedge spi_cs_n) begin
      bitcnt   = 0;
      cs_falls = cs_falls + 1;
      spi_miso = resp(0)[7];
   end
   always @(posedge spi_sclk) if (!spi_cs_n) begin
      t_rise = $realtime;
      msh    = {msh[6:0], spi_mosi};
      bitcnt = bitcnt + 1;
      if (bitcnt % 8 == 0 && bitcnt <= 512) mbytes[bitcnt/8 - 1] = msh;
   end
   always @(negedge spi_sclk) begin
      t_fall = $realtime;
      if ($realtime - t_rise != H * 5.0) hi_bad = hi_bad + 1;
      if (!spi_cs_n) begin
         logic [7:0] b;
         b = resp(bitcnt / 8);
         spi_miso = b[7 - (bitcnt % 8)];
      end
   end
   always @(posedge spi_cs_n) gap = $realtime - t_fall;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_idle(output int polls);
      logic [7:0] v;
      polls = 0;
      do begin
         rd(A_CT, v);
         polls++;
      end while (v[0] && polls < 5000);
   endtask

   task automatic xfer(input int w, input int rc, input bit skip, input int nq);
      logic [7:0] v;
      int polls, nexp, nrd;
      wr(A_Q, 8'(8'h03 + w * 16));
      for (int i = 1; i <= nq; i++) wr(A_Q, pay(w, i));
      wr(A_SZ, 8'((rc << 4) | w));
      rd(A_SZ, v);
      chk(v == 8'((rc << 4) | w), "R4 size readback", v, (rc << 4) | w);
      wr(A_CT, skip ? 8'h05 : 8'h01);
      rd(A_CT, v);
      chk(v[0] == 1'b1, "R6 busy after start", v[0], 1);
      wait_idle(polls);
      chk(spi_cs_n == 1'b1, "R6 idle after trigger clears", spi_cs_n, 1);
      nrd  = skip ? 0 : rc + 1;
      nexp = 1 + w + nrd;
      chk(bitcnt == 8 * nexp, "R5 bit count", bitcnt, 8 * nexp);
      chk(mbytes[0] == 8'(8'h03 + w * 16), "R3 opcode", mbytes[0], 8'h03 + w * 16);
      for (int i = 1; i <= w; i++) begin
         logic [7:0] e;
         e = (i <= nq) ? pay(w, i) : 8'h00;
         chk(mbytes[i] == e, (i <= nq) ? "R3 payload" : "R9 zero fill", mbytes[i], e);
      end
      for (int j = 0; j < nrd; j++)
         chk(mbytes[1 + w + j] == 8'h00, "R9 reply phase mosi", mbytes[1 + w + j], 0);
      chk(gap == 2 * H * 5.0, "R8 cs release gap", int'(gap), 2 * H * 5);
      for (int j = 0; j < nrd; j++) begin
         rd(A_RX, v);
         chk(v == resp(1 + w + j), "R10 reply byte", v, resp(1 + w + j));
      end
      rd(A_RX, v);
      chk(v == 8'h00, "R10 drained read", v, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++; errors++;
         $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int polls, f0;
      #12 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
      chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
      rd(A_CT, v); chk(v == 8'h00, "R1 ctrl", v, 0);
      rd(A_LK, v); chk(v == 8'h00, "R1 lock", v, 0);

      // R2 locked writes ignored
      wr(A_Q, 8'h11);
      wr(A_SZ, 8'h33);
      rd(A_SZ, v); chk(v == 8'h00, "R2 size locked", v, 0);
      f0 = cs_falls;
      wr(A_CT, 8'h01);
      repeat (40) @(negedge clk);
      chk(cs_falls == f0, "R2 locked trigger", cs_falls, f0);
      wr(A_LK, 8'h10);
      rd(A_LK, v); chk(v == 8'h10, "R2 unlock", v, 8'h10);
      wr(A_SZ, 8'h00);
      wr(A_CT, 8'h05);
      wait_idle(polls);
      chk(bitcnt == 8 && mbytes[0] == 8'h00, "R2 locked queue write", mbytes[0], 0);

      // sweep of the main function
      for (int w = 0; w < 16; w++) begin
         int nq;
         nq = (w % 3 == 0) ? w / 2 : w;
         xfer(w, 0, 1'b0, nq);
         xfer(w, 7, 1'b0, nq);
         xfer(w, 15, 1'b0, nq);
         xfer(w, 3, 1'b1, nq);
      end
      chk(hi_bad == 0, "R7 sclk high width", hi_bad, 0);

      // R11 clear bit empties the queue
      wr(A_Q, 8'hA1); wr(A_Q, 8'hA2); wr(A_Q, 8'hA3);
      wr(A_CT, 8'h02);
      wr(A_Q, 8'h9F);
      wr(A_SZ, 8'h01);
      wr(A_CT, 8'h05);
      wait_idle(polls);
      chk(bitcnt == 16, "R11 count", bitcnt, 16);
      chk(mbytes[0] == 8'h9F, "R11 opcode after clear", mbytes[0], 8'h9F);
      chk(mbytes[1] == 8'h00, "R11 stale byte dropped", mbytes[1], 0);

      // R11 clear bit empties the reply buffer
      wr(A_Q, 8'h9F); wr(A_SZ, 8'h20); wr(A_CT, 8'h01);
      wait_idle(polls);
      wr(A_CT, 8'h02);
      rd(A_RX, v); chk(v == 8'h00, "R11 reply cleared", v, 0);

      // R12 busy control write ignored, held bits readback
      wr(A_Q, 8'h0B); wr(A_SZ, 8'hFF); wr(A_CT, 8'h01);
      wr(A_CT, 8'h19);
      wait_idle(polls);
      rd(A_CT, v); chk(v == 8'h00, "R12 busy write ignored", v, 0);
      wr(A_CT, 8'h18);
      rd(A_CT, v); chk(v == 8'h18, "R12 held bits", v, 8'h18);
      wr(A_CT, 8'h04);
      rd(A_CT, v); chk(v == 8'h04, "R12 skip bit", v, 8'h04);

      // R2 relock
      wr(A_LK, 8'h00);
      rd(A_LK, v); chk(v == 8'h00, "R2 relock", v, 0);
      f0 = cs_falls;
      wr(A_CT, 8'h01);
      repeat (40) @(negedge clk);
      chk(cs_falls == f0, "R2 relocked trigger", cs_falls, f0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule